// File: doc/BRIEF.md
# Touch Position Averaging Filter

This block turns a burst of packed touch-panel samples into a single position report. When it gets a start pulse, it pops up to four 32-bit words from an upstream sample FIFO using a valid/ready handshake. It stops early if the FIFO reports empty.

Each word carries one X coordinate field, one Y coordinate field and one pen-level bit. Both coordinates are mirrored into screen orientation by subtracting them from the full-scale code. The block reports a touch only if the burst was complete and the pen was still down in its last word. In that case the reported position is the mean of the two middle samples. Every other burst produces a release report, and the previous position is kept.

If the upstream FIFO reports an overrun when the burst starts, the block empties the FIFO and produces no report. The report stays on the output registers and is marked by a one-cycle strobe.

Top module: `touch_avg_filter`

## Requirements
- R1: A word is popped on a clock edge where `smp_ready_o` and `smp_valid_i` are both high. A non-overrun burst pops at most 4 words and leaves any further words in the FIFO.
- R2: A burst ends as soon as `fifo_empty_i` is high during collection, even if fewer than 4 words were popped.
- R3: Each coordinate is converted as 1023 minus its raw field. X is bits 25:16 of the word and Y is bits 9:0. All other bits except bit 31 are ignored.
- R4: For a touch, the reported X and Y are each the floor of (converted sample 2 + converted sample 3) / 2. The sum is formed at 11 bits, so it cannot wrap.
- R5: A touch report (`rpt_touch_o` = 1) needs exactly 4 popped words and bit 31 = 0 in the fourth word. The pen bits of words 1 to 3 have no effect.
- R6: A burst with fewer than 4 words, or with bit 31 = 1 in the fourth word, gives a report with `rpt_touch_o` = 0. In that case `rpt_x_o` and `rpt_y_o` keep their previous values.
- R7: If `fifo_ovr_i` is high in the cycle the start pulse is accepted, the block pops words until the FIFO is empty and raises no report.
- R8: `rpt_valid_o` is high for exactly one cycle per reported burst. It rises right after the edge that pops the fourth word, or after the edge on which empty ends collection.
- R9: A start pulse that arrives while a burst is in progress is ignored. It starts no second burst and causes no additional pops.
- R10: After reset, `smp_ready_o`, `rpt_valid_o` and `rpt_touch_o` are 0, and `rpt_x_o` and `rpt_y_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to process a burst |
| fifo_ovr_i | input | 1 | Upstream FIFO overrun status |
| fifo_empty_i | input | 1 | Upstream FIFO empty status |
| smp_valid_i | input | 1 | Upstream word available |
| smp_data_i | input | 32 | Packed sample: pen bit 31, X bits 25:16, Y bits 9:0 |
| smp_ready_o | output | 1 | Pop request to the upstream FIFO |
| rpt_valid_o | output | 1 | One-cycle report strobe |
| rpt_touch_o | output | 1 | 1 = touch with new position, 0 = release |
| rpt_x_o | output | 10 | Reported X position |
| rpt_y_o | output | 10 | Reported Y position |

## Verification
A wrong burst counter or state shows up at the ports within one burst, in one of three ways:
- an extra or missing word removed from the FIFO, which is visible as leftover occupancy after the report;
- a report strobe that arrives on the wrong edge;
- a report where none should appear, for example after an overrun drain.

A wrong middle-sample sum shows up in the very next touch report as a position off by the mis-added amount. A flaw in the hold logic shows up on the first release that follows a touch.

The sweeps drive many coordinate pairs, all 16 pen-bit patterns and every short burst length, and compare each outcome with values the bench computes arithmetically.

// File: rtl/tafl_pkg.sv
package tafl_pkg;

  localparam int COORD_W = 10;
  localparam int SUM_W   = COORD_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_DRAIN   = 2'd2
  } tafl_state_e;

  // Mirror a raw code into screen orientation.
  function automatic logic [COORD_W-1:0] flip_coord(input logic [COORD_W-1:0] raw);
    logic [COORD_W-1:0] full_scale;
    full_scale = '1;
    return full_scale - raw;
  endfunction

  // Floor of the mean of two values whose sum is given at full width.
  function automatic logic [COORD_W-1:0] half_of_sum(input logic [SUM_W-1:0] sum);
    return sum[SUM_W-1:1];
  endfunction

endpackage

// File: rtl/tafl_sample_conv.sv
module tafl_sample_conv
  import tafl_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int X_LSB   = 16,
  parameter int Y_LSB   = 0,
  parameter int PEN_BIT = 31
) (
  input  logic [WORD_W-1:0]  word_i,
  output logic [COORD_W-1:0] x_o,
  output logic [COORD_W-1:0] y_o,
  output logic               pen_up_o
);

  logic [COORD_W-1:0] raw_x;
  logic [COORD_W-1:0] raw_y;
  logic               unused_word_bits;

  assign raw_x    = word_i[X_LSB +: COORD_W];
  assign raw_y    = word_i[Y_LSB +: COORD_W];
  assign pen_up_o = word_i[PEN_BIT];
  assign x_o      = flip_coord(raw_x);
  assign y_o      = flip_coord(raw_y);

  // Bits outside the three fields carry no meaning for this block.
  assign unused_word_bits = ^word_i;

endmodule

// File: rtl/tafl_burst_ctrl.sv
module tafl_burst_ctrl
  import tafl_pkg::*;
#(
  parameter int BURST_LEN = 4,
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ovr_i,
  input  logic             empty_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             pop_o,
  output logic             clr_o,
  output logic             finish_o,
  output logic             full_o,
  output logic             collect_o,
  output logic [CNT_W-1:0] idx_o
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BURST_LEN - 1);

  tafl_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             idle;

  assign idle      = (state_q == ST_IDLE);
  assign collect_o = (state_q == ST_COLLECT);
  assign clr_o     = idle && start_i;
  assign ready_o   = !idle && !empty_i;
  assign pop_o     = ready_o && valid_i;
  assign full_o    = collect_o && pop_o && (cnt_q == LAST_IDX);
  assign finish_o  = collect_o && (empty_i || full_o);
  assign idx_o     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start_i) state_q <= ovr_i ? ST_DRAIN : ST_COLLECT;
        end
        ST_COLLECT: begin
          if (pop_o) cnt_q <= cnt_q + 1'b1;
          if (finish_o) state_q <= ST_IDLE;
        end
        ST_DRAIN: begin
          if (empty_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  no_fifth_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |=> !ready_o);

  // R2
  early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (collect_o && empty_i) |=> idle);

  // R7
  drain_until_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && !empty_i) |=> (state_q == ST_DRAIN));

endmodule

// File: rtl/tafl_mid_accum.sv
module tafl_mid_accum
  import tafl_pkg::*;
#(
  parameter int BURST_LEN = 4,
  localparam int CNT_W    = $clog2(BURST_LEN + 1),
  localparam int MID_A    = BURST_LEN / 2 - 1,
  localparam int MID_B    = BURST_LEN / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               pop_i,
  input  logic [CNT_W-1:0]   idx_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic [SUM_W-1:0]   sum_x_o,
  output logic [SUM_W-1:0]   sum_y_o
);

  logic take;

  assign take = pop_i && ((idx_i == CNT_W'(MID_A)) || (idx_i == CNT_W'(MID_B)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_x_o <= '0;
      sum_y_o <= '0;
    end else if (clr_i) begin
      sum_x_o <= '0;
      sum_y_o <= '0;
    end else if (take) begin
      sum_x_o <= sum_x_o + SUM_W'(x_i);
      sum_y_o <= sum_y_o + SUM_W'(y_i);
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_i) |-> (sum_x_o >= $past(sum_x_o) && sum_y_o >= $past(sum_y_o)));

endmodule

// File: rtl/touch_avg_filter.sv
module touch_avg_filter
  import tafl_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int WORD_W    = 32,
  parameter int X_LSB     = 16,
  parameter int Y_LSB     = 0,
  parameter int PEN_BIT   = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fifo_ovr_i,
  input  logic              fifo_empty_i,
  input  logic              smp_valid_i,
  input  logic [WORD_W-1:0] smp_data_i,
  output logic              smp_ready_o,
  output logic              rpt_valid_o,
  output logic              rpt_touch_o,
  output logic [9:0]        rpt_x_o,
  output logic [9:0]        rpt_y_o
);

  localparam int CNT_W = $clog2(BURST_LEN + 1);

  // Internal events brought out as named wires.
  logic               ev_pop;
  logic               ev_clr;
  logic               ev_finish;
  logic               ev_full;
  logic               ev_collect;
  logic               ev_touch;
  logic [CNT_W-1:0]   burst_idx;
  logic [COORD_W-1:0] cur_x;
  logic [COORD_W-1:0] cur_y;
  logic               cur_pen_up;
  logic [SUM_W-1:0]   sum_x;
  logic [SUM_W-1:0]   sum_y;

  logic               valid_q;
  logic               touch_q;
  logic [COORD_W-1:0] x_q;
  logic [COORD_W-1:0] y_q;

  tafl_burst_ctrl #(.BURST_LEN(BURST_LEN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ovr_i     (fifo_ovr_i),
    .empty_i   (fifo_empty_i),
    .valid_i   (smp_valid_i),
    .ready_o   (smp_ready_o),
    .pop_o     (ev_pop),
    .clr_o     (ev_clr),
    .finish_o  (ev_finish),
    .full_o    (ev_full),
    .collect_o (ev_collect),
    .idx_o     (burst_idx)
  );

  tafl_sample_conv #(
    .WORD_W (WORD_W),
    .X_LSB  (X_LSB),
    .Y_LSB  (Y_LSB),
    .PEN_BIT(PEN_BIT)
  ) u_conv (
    .word_i  (smp_data_i),
    .x_o     (cur_x),
    .y_o     (cur_y),
    .pen_up_o(cur_pen_up)
  );

  tafl_mid_accum #(.BURST_LEN(BURST_LEN)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ev_clr),
    .pop_i  (ev_pop && ev_collect),
    .idx_i  (burst_idx),
    .x_i    (cur_x),
    .y_i    (cur_y),
    .sum_x_o(sum_x),
    .sum_y_o(sum_y)
  );

  // The last word of a full burst is judged as it is popped.
  assign ev_touch = ev_full && !cur_pen_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      touch_q <= 1'b0;
      x_q     <= '0;
      y_q     <= '0;
    end else begin
      valid_q <= ev_finish;
      if (ev_finish) touch_q <= ev_touch;
      if (ev_touch) begin
        x_q <= half_of_sum(sum_x);
        y_q <= half_of_sum(sum_y);
      end
    end
  end

  assign rpt_valid_o = valid_q;
  assign rpt_touch_o = touch_q;
  assign rpt_x_o     = x_q;
  assign rpt_y_o     = y_q;

  // R8
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid_o |=> !rpt_valid_o);

  // R6
  release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid_o && !rpt_touch_o) |-> ($stable(rpt_x_o) && $stable(rpt_y_o)));

  // R7
  report_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid_o |-> $past(ev_collect));

  // R5
  touch_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpt_touch_o) |-> rpt_valid_o);

endmodule

// File: tb/touch_avg_filter_tb.sv
module touch_avg_filter_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ovr = 1'b0;
  logic        ready;
  logic        rvalid;
  logic        rtouch;
  logic [9:0]  rx;
  logic [9:0]  ry;

  // Upstream FIFO model: the initial block writes, the pop process reads.
  logic [31:0] fq [0:15];
  logic [4:0]  wr_ptr = '0;
  logic [4:0]  rd_ptr = '0;
  logic        empty;
  logic [31:0] head;
  logic [4:0]  occ;

  assign occ   = wr_ptr - rd_ptr;
  assign empty = (occ == 5'd0);
  assign head  = fq[rd_ptr[3:0]];

  always @(posedge clk) if (ready && !empty) rd_ptr <= rd_ptr + 5'd1;

  int rep_cnt = 0;
  logic cap_touch;
  logic [9:0] cap_x, cap_y;
  always @(negedge clk) if (rvalid) begin
    rep_cnt   <= rep_cnt + 1;
    cap_touch <= rtouch;
    cap_x     <= rx;
    cap_y     <= ry;
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  touch_avg_filter u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .fifo_ovr_i  (ovr),
    .fifo_empty_i(empty),
    .smp_valid_i (!empty),
    .smp_data_i  (head),
    .smp_ready_o (ready),
    .rpt_valid_o (rvalid),
    .rpt_touch_o (rtouch),
    .rpt_x_o     (rx),
    .rpt_y_o     (ry)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Word layout: pen bit 31, X 25:16, Y 9:0; filler in the other bits.
  function automatic logic [31:0] mk(input bit pen, input int x, input int y);
    return {pen, 5'h15, x[9:0], 6'h2A, y[9:0]};
  endfunction

  function automatic int avg_flip(input int a, input int b);
    return ((1023 - a) + (1023 - b)) / 2;
  endfunction

  task automatic push(input logic [31:0] w);
    fq[wr_ptr[3:0]] = w;
    wr_ptr = wr_ptr + 5'd1;
  endtask

  task automatic run(input bit with_ovr);
    @(negedge clk);
    start = 1'b1;
    ovr   = with_ovr;
    @(negedge clk);
    start = 1'b0;
    ovr   = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  int hx, hy;

  task automatic touch_burst(input int x1, input int x2, input int y1, input int y2, input string tag);
    int base;
    int ex, ey;
    base = rep_cnt;
    push(mk(0, 7, 9));
    push(mk(0, x1, y1));
    push(mk(0, x2, y2));
    push(mk(0, 3, 4));
    run(1'b0);
    ex = avg_flip(x1, x2);
    ey = avg_flip(y1, y2);
    check(rep_cnt == base + 1 && cap_touch, {tag, " R5 touch"}, rep_cnt - base, 1);
    check(cap_x == ex, {tag, " R4 x"}, cap_x, ex);
    check(cap_y == ey, {tag, " R3 y"}, cap_y, ey);
    check(occ == 0, {tag, " R1 drained"}, occ, 0);
    hx = ex;
    hy = ey;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(ready == 0, "R10 ready", ready, 0);
    check(rvalid == 0 && rtouch == 0, "R10 valid/touch", {rvalid, rtouch}, 0);
    check(rx == 0 && ry == 0, "R10 xy", rx, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Boundary coordinates, R4 sum without wrap
    touch_burst(0, 0, 0, 0, "bnd0");
    touch_burst(1023, 1023, 1023, 1023, "bndmax");
    touch_burst(0, 1, 1, 0, "bndodd");

    // Coordinate sweep
    for (int k = 0; k < 64; k++)
      touch_burst((k * 37) & 1023, (k * 91 + 5) & 1023, (k * 53 + 11) & 1023, (k * 17 + 600) & 1023, "sweep");

    // R8 strobe timing: valid only after the 4th pop edge
    push(mk(0, 100, 200)); push(mk(0, 300, 400)); push(mk(0, 500, 600)); push(mk(0, 1, 2));
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    check(rvalid == 0, "R8 early", rvalid, 0);
    @(negedge clk);
    check(rvalid == 1, "R8 on time", rvalid, 1);
    @(negedge clk);
    check(rvalid == 0, "R8 one cycle", rvalid, 0);
    hx = avg_flip(300, 500);
    hy = avg_flip(400, 600);
    repeat (4) @(negedge clk);

    // All pen-bit patterns: only the 4th word matters (R5, R6)
    for (int p = 0; p < 16; p++) begin
      int base;
      base = rep_cnt;
      push(mk(p[0], 10 + p, 20 + p));
      push(mk(p[1], 30 + p, 40 + p));
      push(mk(p[2], 50 + p, 60 + p));
      push(mk(p[3], 70 + p, 80 + p));
      run(1'b0);
      check(rep_cnt == base + 1, "R8 one report", rep_cnt - base, 1);
      if (!p[3]) begin
        hx = avg_flip(30 + p, 50 + p);
        hy = avg_flip(40 + p, 60 + p);
        check(cap_touch == 1, "R5 pen pattern touch", cap_touch, 1);
      end else begin
        check(cap_touch == 0, "R6 last pen up release", cap_touch, 0);
      end
      check(cap_x == hx && cap_y == hy, "R6 position", cap_x, hx);
    end

    // Short bursts 0..3 words (R2, R6)
    for (int n = 0; n < 4; n++) begin
      int base;
      base = rep_cnt;
      for (int i = 0; i < n; i++) push(mk(0, 900 - i, 800 - i));
      run(1'b0);
      check(rep_cnt == base + 1 && cap_touch == 0, "R2 short release", cap_touch, 0);
      check(cap_x == hx && cap_y == hy, "R6 short hold", cap_x, hx);
      check(occ == 0, "R2 short drained", occ, 0);
    end

    // Six words, second start while busy (R1, R9)
    begin
      int base;
      base = rep_cnt;
      for (int i = 0; i < 6; i++) push(mk(0, 200 + i, 300 + i));
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (12) @(negedge clk);
      check(rep_cnt == base + 1, "R9 single report", rep_cnt - base, 1);
      check(occ == 2, "R1 leftover words", occ, 2);
      check(cap_x == avg_flip(201, 202), "R4 x six", cap_x, avg_flip(201, 202));
      hx = cap_x;
      hy = cap_y;
    end

    // Overrun: drain everything, no report (R7)
    begin
      int base;
      base = rep_cnt;
      for (int i = 0; i < 5; i++) push(mk(0, 1, 1));
      run(1'b1);
      check(rep_cnt == base, "R7 no report", rep_cnt - base, 0);
      check(occ == 0, "R7 drained", occ, 0);
      check(rx == hx && ry == hy, "R7 xy untouched", rx, hx);
    end

    // After overrun, normal operation resumes
    touch_burst(512, 511, 0, 1023, "post");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule